// File: doc/BRIEF.md
# Serial Port Bit-Timing Tick Generator

This block produces the timing enables that a serial port's receiver and transmitter run on. It picks one of several event sources: every module clock, the module clock pre-divided by a fixed count, or rising edges of an external clock pin brought into the module clock domain. It counts those events with a programmable divisor and emits a single-cycle sampling enable every time the divisor is reached. In asynchronous operation a second stage counts sampling enables, 16 or 8 of them, to make the bit-rate enable. In synchronous operation the bit-rate enable is the sampling enable itself.

A divisor of zero switches the generator off. A divisor of one bypasses the counter, so every source event becomes a sampling enable. Any change to the divisor, the source code or the oversampling choice restarts the whole counting chain. The first enable after such a change therefore arrives one full period later. Both outputs are enables in the module clock domain, so downstream logic needs no second clock.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is held, both outputs are low. After reset is released with an unchanged configuration, the first sampling enable appears exactly one full divisor period of source events later.
- R2: Source code 0 yields one source event per module clock, so with divisor N ≥ 2 a sampling enable occurs every N clocks.
- R3: Source code 1 yields one source event per 8 module clocks from a free-running counter, so with divisor N a sampling enable occurs every 8·N clocks.
- R4: Source code 3 takes the external pin through two synchronizing flops and makes one source event per rising edge of the synchronized signal, three module clocks after the pin rises.
- R5: Source code 2 is reserved and produces no source events, so no sampling or bit-rate enable occurs.
- R6: A divisor of 0 produces no sampling enable and no bit-rate enable.
- R7: A divisor of 1 bypasses the counter, and every source event produces a sampling enable on the next clock.
- R8: In asynchronous mode the bit-rate enable accompanies every 16th sampling enable when the oversampling bit is 0, and every 8th when it is 1.
- R9: In synchronous mode every sampling enable is also a bit-rate enable.
- R10: A change to the divisor, the source code or the oversampling bit clears the pre-divider, divisor and oversampling counters and drops the source event of that clock. No sampling enable follows on the next clock, and counting restarts from zero.
- R11: The bit-rate enable is only ever high together with the sampling enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Source code: 0 module clock, 1 module clock / 8, 2 reserved, 3 external pin |
| cd | input | CD_W (16) | Divisor; 0 off, 1 bypass |
| ovs_sel | input | 1 | Oversampling choice: 0 for 16x, 1 for 8x |
| sync_mode | input | 1 | 1 makes the bit-rate enable equal the sampling enable |
| ext_clk | input | 1 | External clock pin, asynchronous to clk |
| samp_tick | output | 1 | Sampling enable, one clock wide |
| baud_tick | output | 1 | Bit-rate enable, one clock wide |

## Verification
The bench targets the two special divisor values. A generator that treated 0 as a huge divisor would still tick now and then, and one that failed to bypass on 1 would halve the rate. It changes only the oversampling bit after the second-stage counter has run past 7: if the restart were missing, the 8x bit-rate enable would not appear until that counter wrapped through 15. It also changes the divisor in the middle of a period. A design that kept the old count would fire early. The external-pin run checks the exact three-clock synchronizer latency, and the reserved source code must stay silent.

// File: rtl/bt_pkg.sv
package bt_pkg;

   typedef enum logic [1:0] {
      SRC_CORE     = 2'd0,
      SRC_CORE_DIV = 2'd1,
      SRC_RSVD     = 2'd2,
      SRC_EXT      = 2'd3
   } src_e;

endpackage

// File: rtl/bt_src_sel.sv
module bt_src_sel #(
   parameter int PREDIV      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  bt_pkg::src_e src_sel,
   input  logic         ext_clk,
   output logic         src_ev
);

   localparam int PD_W = (PREDIV > 2) ? $clog2(PREDIV) : 1;
   localparam logic [PD_W-1:0] PD_LAST = PD_W'(PREDIV - 1);
   localparam bit PD_POW2 = ((PREDIV & (PREDIV - 1)) == 0);

   if (PREDIV < 2) begin : g_bad_prediv
      $error("bt_src_sel: PREDIV must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("bt_src_sel: SYNC_STAGES must be at least 2");
   end

   // external pin synchronizer and edge detector
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   ext_prev_q;
   logic                   ext_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q     <= '0;
         ext_prev_q <= 1'b0;
      end else begin
         sync_q     <= {sync_q[SYNC_STAGES-2:0], ext_clk};
         ext_prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign ext_rise = sync_q[SYNC_STAGES-1] & ~ext_prev_q;

   // free-running pre-divider
   logic [PD_W-1:0] pd_q;
   logic            pd_tick;

   assign pd_tick = (pd_q == PD_LAST);

   if (PD_POW2) begin : g_pd_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   pd_q <= '0;
         else if (clr) pd_q <= '0;
         else          pd_q <= pd_q + 1'b1;
      end
   end else begin : g_pd_cmp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       pd_q <= '0;
         else if (clr)     pd_q <= '0;
         else if (pd_tick) pd_q <= '0;
         else              pd_q <= pd_q + 1'b1;
      end
   end

   // source multiplexer
   logic raw_ev;

   always_comb begin
      unique case (src_sel)
         bt_pkg::SRC_CORE:     raw_ev = 1'b1;
         bt_pkg::SRC_CORE_DIV: raw_ev = pd_tick;
         bt_pkg::SRC_EXT:      raw_ev = ext_rise;
         default:              raw_ev = 1'b0;
      endcase
   end

   assign src_ev = raw_ev & ~clr;

endmodule

// File: rtl/bt_divider.sv
module bt_divider #(
   parameter int CD_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            src_ev,
   input  logic [CD_W-1:0] cd,
   output logic            samp_tick
);

   localparam logic [CD_W-1:0] ONE = CD_W'(1);

   if (CD_W < 2) begin : g_bad_cdw
      $error("bt_divider: CD_W must be at least 2");
   end

   logic [CD_W-1:0] dc_q;
   logic [CD_W-1:0] cd_m1;
   logic            is_off;
   logic            is_bypass;
   logic            at_end;
   logic            counting;
   logic            hit;

   assign cd_m1     = cd - ONE;
   assign is_off    = (cd == '0);
   assign is_bypass = (cd == ONE);
   assign at_end    = (dc_q == cd_m1);
   assign counting  = src_ev & ~is_off & ~is_bypass;
   assign hit       = src_ev & ~is_off & (is_bypass | at_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dc_q <= '0;
      end else if (clr) begin
         dc_q <= '0;
      end else if (counting) begin
         dc_q <= at_end ? '0 : dc_q + ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) samp_tick <= 1'b0;
      else        samp_tick <= hit;
   end

endmodule

// File: rtl/bt_ovs.sv
module bt_ovs #(
   parameter int OVS_HI = 16,
   parameter int OVS_LO = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic samp_tick,
   input  logic ovs_sel,
   input  logic sync_mode,
   output logic baud_tick
);

   localparam int OC_W = $clog2(OVS_HI);
   localparam logic [OC_W-1:0] WRAP_HI = OC_W'(OVS_HI - 1);
   localparam logic [OC_W-1:0] WRAP_LO = OC_W'(OVS_LO - 1);

   if (OVS_LO < 2) begin : g_bad_lo
      $error("bt_ovs: OVS_LO must be at least 2");
   end
   if (OVS_HI < OVS_LO) begin : g_bad_hi
      $error("bt_ovs: OVS_HI must not be below OVS_LO");
   end

   logic [OC_W-1:0] oc_q;
   logic [OC_W-1:0] wrap;
   logic            at_wrap;
   logic            restart;

   assign wrap    = ovs_sel ? WRAP_LO : WRAP_HI;
   assign at_wrap = (oc_q == wrap);
   assign restart = sync_mode | at_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oc_q <= '0;
      end else if (clr) begin
         oc_q <= '0;
      end else if (samp_tick) begin
         oc_q <= restart ? '0 : oc_q + 1'b1;
      end
   end

   assign baud_tick = samp_tick & restart;

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
   parameter int CD_W        = 16,
   parameter int PREDIV      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int OVS_HI      = 16,
   parameter int OVS_LO      = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      src_sel,
   input  logic [CD_W-1:0] cd,
   input  logic            ovs_sel,
   input  logic            sync_mode,
   input  logic            ext_clk,
   output logic            samp_tick,
   output logic            baud_tick
);

   // configuration shadow, captured every clock, used to spot changes
   logic [CD_W-1:0] cd_q;
   logic [1:0]      src_q;
   logic            ovs_q;
   logic            cfg_chg;

   always_ff @(posedge clk) begin
      cd_q  <= cd;
      src_q <= src_sel;
      ovs_q <= ovs_sel;
   end

   assign cfg_chg = (cd != cd_q) | (src_sel != src_q) | (ovs_sel != ovs_q);

   logic src_ev;

   bt_src_sel #(
      .PREDIV      (PREDIV),
      .SYNC_STAGES (SYNC_STAGES)
   ) src_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (cfg_chg),
      .src_sel (bt_pkg::src_e'(src_sel)),
      .ext_clk (ext_clk),
      .src_ev  (src_ev)
   );

   bt_divider #(
      .CD_W (CD_W)
   ) div_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (cfg_chg),
      .src_ev    (src_ev),
      .cd        (cd),
      .samp_tick (samp_tick)
   );

   bt_ovs #(
      .OVS_HI (OVS_HI),
      .OVS_LO (OVS_LO)
   ) ovs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (cfg_chg),
      .samp_tick (samp_tick),
      .ovs_sel   (ovs_sel),
      .sync_mode (sync_mode),
      .baud_tick (baud_tick)
   );

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
   parameter int CD_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      src_sel,
   input logic [CD_W-1:0] cd,
   input logic            ovs_sel,
   input logic            sync_mode,
   input logic            samp_tick,
   input logic            baud_tick
);

   assert_baud_in_samp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |-> samp_tick);

   assert_off_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cd) == '0) |-> !samp_tick);

   assert_rsvd_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(src_sel) == 2'd2) |-> !samp_tick);

   assert_restart_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(cd) != $past(cd, 2)) || ($past(src_sel) != $past(src_sel, 2)) ||
       ($past(ovs_sel) != $past(ovs_sel, 2))) |-> !samp_tick);

   assert_sync_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode && samp_tick) |-> baud_tick);

   assert_bypass_every_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cd) == CD_W'(1) && $past(src_sel) == 2'd0 &&
       $past(cd) == $past(cd, 2) && $past(src_sel) == $past(src_sel, 2) &&
       $past(ovs_sel) == $past(ovs_sel, 2)) |-> samp_tick);

endmodule

bind baud_tick_gen baud_tick_gen_chk #(.CD_W(CD_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_sel   (src_sel),
   .cd        (cd),
   .ovs_sel   (ovs_sel),
   .sync_mode (sync_mode),
   .samp_tick (samp_tick),
   .baud_tick (baud_tick)
);

// File: tb/baud_tick_gen_tb_top.sv
`timescale 1ns/1ps
module baud_tick_gen_tb_top;

   localparam int PRE = 8;
   localparam int HI  = 16;
   localparam int LO  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  src_in = 2'd0;
   logic [15:0] cd_in = 16'd0;
   logic        ovs_in = 1'b0;
   logic        sync_in = 1'b0;
   logic        ext_in = 1'b0;
   logic        samp_tick;
   logic        baud_tick;

   always #2 clk = ~clk;

   baud_tick_gen dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_sel   (src_in),
      .cd        (cd_in),
      .ovs_sel   (ovs_in),
      .sync_mode (sync_in),
      .ext_clk   (ext_in),
      .samp_tick (samp_tick),
      .baud_tick (baud_tick)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural reference model
   int m_pd, m_dc, m_ovc, m_cdq, m_srcq, m_ovsq;
   bit m_samp, m_chg, m_ev, m_hit, m_old;
   bit hist[$] = '{1'b0, 1'b0, 1'b0};

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pd = 0; m_dc = 0; m_ovc = 0; m_samp = 0;
         hist = '{1'b0, 1'b0, 1'b0};
      end else begin
         m_chg = (int'(cd_in) != m_cdq) || (int'(src_in) != m_srcq) || (int'(ovs_in) != m_ovsq);
         case (src_in)
            2'd0:    m_ev = 1;
            2'd1:    m_ev = (m_pd == PRE - 1);
            2'd3:    m_ev = hist[1] && !hist[2];
            default: m_ev = 0;
         endcase
         if (m_chg) m_ev = 0;
         if (cd_in == 1) m_hit = m_ev;
         else            m_hit = (cd_in >= 2) && m_ev && (m_dc == int'(cd_in) - 1);
         m_old = m_samp;
         if (m_chg) begin
            m_pd = 0; m_dc = 0; m_ovc = 0;
         end else begin
            m_pd = (m_pd + 1) % PRE;
            if (cd_in >= 2 && m_ev) m_dc = (m_dc == int'(cd_in) - 1) ? 0 : m_dc + 1;
            if (m_old) m_ovc = (sync_in || m_ovc == (ovs_in ? LO - 1 : HI - 1)) ? 0 : m_ovc + 1;
         end
         m_samp = m_hit;
         hist.push_front(ext_in);
         void'(hist.pop_back());
      end
      m_cdq  = int'(cd_in);
      m_srcq = int'(src_in);
      m_ovsq = int'(ovs_in);
   end

   int ph_s, ph_b, ph_first;

   // runs len clocks, comparing with the model after every edge
   task automatic run_phase(input string req, input int s, input int c, input bit o,
                            input bit y, input bit ext_drive, input int len);
      bit eb;
      src_in = 2'(s); cd_in = 16'(c); ovs_in = o; sync_in = y;
      ph_s = 0; ph_b = 0; ph_first = -1;
      for (int i = 0; i < len; i++) begin
         @(posedge clk); #1;
         eb = m_samp && (sync_in || m_ovc == (ovs_in ? LO - 1 : HI - 1));
         chk({req, " samp_tick vs model"}, int'(samp_tick), int'(m_samp));
         chk({req, " baud_tick vs model"}, int'(baud_tick), int'(eb));
         chk("R11 baud without samp", int'(baud_tick & ~samp_tick), 0);
         if (samp_tick) begin
            ph_s++;
            if (ph_first < 0) ph_first = i;
         end
         if (baud_tick) ph_b++;
         if (ext_drive) ext_in = ((i % 6) < 3);
      end
   endtask

   initial begin
      // R1: reset state
      src_in = 2'd0; cd_in = 16'd5; ovs_in = 1'b1; sync_in = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 samp_tick in reset", int'(samp_tick), 0);
      chk("R1 baud_tick in reset", int'(baud_tick), 0);
      rst_n = 1'b1;
      run_phase("R1", 0, 5, 1, 0, 0, 50);
      chk("R1 first samp index", ph_first, 4);
      chk("R1 samp count", ph_s, 10);
      chk("R1 baud count", ph_b, 1);

      run_phase("R2", 0, 5, 1, 0, 0, 1);  // settle, no change
      run_phase("R2", 0, 7, 1, 0, 0, 1);
      run_phase("R2", 0, 5, 1, 0, 0, 200);
      chk("R2 samp count cd5", ph_s, 39);
      chk("R8 baud count 8x", ph_b, 4);

      run_phase("R8", 0, 3, 0, 0, 0, 200);
      chk("R2 samp count cd3", ph_s, 66);
      chk("R8 baud count 16x", ph_b, 4);

      run_phase("R3", 1, 2, 1, 0, 0, 200);
      chk("R3 samp count prediv", ph_s, 12);
      chk("R3 baud count prediv", ph_b, 1);

      run_phase("R7", 0, 1, 0, 0, 0, 40);
      chk("R7 samp count bypass", ph_s, 39);
      chk("R7 baud count bypass", ph_b, 2);

      run_phase("R7", 1, 1, 0, 0, 0, 40);
      chk("R7 samp count bypass prediv", ph_s, 4);

      run_phase("R6", 0, 0, 0, 0, 0, 50);
      chk("R6 samp count off", ph_s, 0);
      chk("R6 baud count off", ph_b, 0);

      run_phase("R5", 2, 3, 0, 0, 0, 50);
      chk("R5 samp count reserved", ph_s, 0);
      chk("R5 baud count reserved", ph_b, 0);

      run_phase("R9", 0, 6, 0, 1, 0, 100);
      chk("R9 samp count sync", ph_s, 16);
      chk("R9 baud count sync", ph_b, 16);

      run_phase("R4", 3, 2, 1, 0, 1, 120);
      chk("R4 samp count ext", ph_s, 10);
      chk("R4 first samp ext", ph_first, 9);
      chk("R4 baud count ext", ph_b, 1);
      ext_in = 1'b0;

      run_phase("R10", 0, 10, 0, 0, 0, 7);
      chk("R10 no samp before period", ph_s, 0);
      run_phase("R10", 0, 12, 0, 0, 0, 30);
      chk("R10 samp count after cd change", ph_s, 2);
      chk("R10 first samp after cd change", ph_first, 12);

      run_phase("R10", 0, 1, 0, 0, 0, 12);
      run_phase("R10", 0, 1, 1, 0, 0, 20);
      chk("R10 samp count after ovs change", ph_s, 19);
      chk("R10 baud count after ovs change", ph_b, 2);

      // reset in mid-run
      rst_n = 1'b0;
      src_in = 2'd0; cd_in = 16'd4; ovs_in = 1'b0; sync_in = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      chk("R1 samp_tick in second reset", int'(samp_tick), 0);
      chk("R1 baud_tick in second reset", int'(baud_tick), 0);
      rst_n = 1'b1;
      run_phase("R1", 0, 4, 0, 0, 0, 80);
      chk("R1 first samp after second reset", ph_first, 3);
      chk("R8 baud count after second reset", ph_b, 1);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule